// File: doc/BRIEF.md
# Four-Way Recency Stack for Cache Replacement

This block keeps the use order of the four lines of one set in a 4-way set-associative cache. The order is held as a short stack of line numbers. The top slot names the most recently used line and the bottom slot names the least recently used line. The bottom slot is driven straight out as the replacement candidate.

When the cache reports a hit, the accessed line number goes to the top of the stack. The slots above its old position each move down by one, and the slots below it keep their places. This is done with a single-cycle conditional shift. Each slot is enabled only if every slot above it holds a number different from the accessed one, so the shift stops at the slot where the match was found.

When the cache replaces a line on a miss, the miss strobe loads the replaced line into the top slot. The replaced line is the one named by the victim output. The other three slots each move down one place. On that strobe the access-line input is not used.

Top module: `lru_shift_stack`

## Requirements
- R1: After reset the stack order is line 0 (most recent), 1, 2, 3 (least recent), so `victim_line` reads 3.
- R2: On a hit to line L, the next cycle has L on top. Slots that were above L move down one place and slots below L keep their places. The four slots always hold four distinct line numbers.
- R3: A hit to the line already on top leaves the whole order unchanged.
- R4: A hit to the least recent line shifts every slot down by one, so the next victim is the line that was third.
- R5: A miss strobe (with `hit_stb` low) puts the current victim on top and shifts the other slots down one place. `acc_line` has no effect on this update.
- R6: When `hit_stb` and `miss_stb` are both high, the update is exactly the hit update for `acc_line`.
- R7: With both strobes low the order does not change.
- R8: The reference string a b c d a b e a b c d e, with resident blocks taken as hits and other blocks filled through the miss strobe into the victim line, ends with the order e, d, c, b from top to bottom. In that run the victim is the line that holds b, which is line 2.
- R9: `victim_line` is a combinational copy of the bottom slot and changes in the cycle after the strobe that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_line | input | 2 | Line number hit by the current access |
| hit_stb | input | 1 | A hit to `acc_line` in this set |
| miss_stb | input | 1 | The victim line was refilled |
| victim_line | output | 2 | Least recently used line, the replacement candidate |

## Verification
The only view of the order at the ports is the bottom slot. Any wrong slot therefore stays hidden until the shifts carry it down to the victim position. This takes at most three further updates, for example three miss strobes or hits to the other lines. The bench compares the victim after every step of a long random hit/miss mix against its own model of the stack, so a misplaced or duplicated entry shows up within a few steps. A stopping point off by one position also shows up within a few steps.

// File: rtl/lru_pkg.sv
package lru_pkg;
    localparam int WAYS   = 4;
    localparam int LINE_W = $clog2(WAYS);

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_MISS = 2'd2
    } op_e;

    typedef struct packed {
        line_t [WAYS-1:0] slot;   // slot[0] most recent, slot[WAYS-1] least recent
    } stack_t;
endpackage

// File: rtl/lru_op_decode.sv
module lru_op_decode
    import lru_pkg::*;
(
    input  logic  hit_stb,
    input  logic  miss_stb,
    input  line_t acc_line,
    input  line_t bottom_line,
    output op_e   op,
    output line_t in_line
);
    always_comb begin
        op      = OP_IDLE;
        in_line = acc_line;
        if (hit_stb) begin
            op      = OP_HIT;          // hit has priority over miss
            in_line = acc_line;
        end else if (miss_stb) begin
            op      = OP_MISS;
            in_line = bottom_line;     // replaced line goes to the top
        end
    end
endmodule

// File: rtl/lru_shift_enable.sv
module lru_shift_enable
    import lru_pkg::*;
(
    input  stack_t          stack_q,
    input  line_t           in_line,
    input  op_e             op,
    output logic [WAYS-1:0] shift_en
);
    logic [WAYS-1:0] differs;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign differs[g] = (stack_q.slot[g] != in_line);
    end

    assign shift_en[0] = (op != OP_IDLE);
    for (genvar g = 1; g < WAYS; g++) begin : g_chain
        assign shift_en[g] = shift_en[g-1] & differs[g-1];
    end
endmodule

// File: rtl/lru_shift_stack.sv
module lru_shift_stack
    import lru_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              hit_stb,
    input  logic              miss_stb,
    output logic [LINE_W-1:0] victim_line
);
    stack_t          stack_d, stack_q;
    op_e             op;
    line_t           in_line;
    logic [WAYS-1:0] shift_en;

    lru_op_decode i_decode (
        .hit_stb     (hit_stb),
        .miss_stb    (miss_stb),
        .acc_line    (acc_line),
        .bottom_line (stack_q.slot[WAYS-1]),
        .op          (op),
        .in_line     (in_line)
    );

    lru_shift_enable i_enable (
        .stack_q  (stack_q),
        .in_line  (in_line),
        .op       (op),
        .shift_en (shift_en)
    );

    always_comb begin
        stack_d = stack_q;
        for (int i = 0; i < WAYS; i++) begin
            if (shift_en[i]) begin
                if (i == 0) stack_d.slot[i] = in_line;
                else        stack_d.slot[i] = stack_q.slot[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) stack_q.slot[i] <= line_t'(i);
        end else begin
            stack_q <= stack_d;
        end
    end

    assign victim_line = stack_q.slot[WAYS-1];
endmodule

// File: rtl/lru_stack_checker.sv
module lru_stack_checker
    import lru_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   hit_stb,
    input logic   miss_stb,
    input line_t  acc_line,
    input line_t  victim_line,
    input stack_t stack_q
);
    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) seen[stack_q.slot[i]] = 1'b1;
    end

    assert_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == WAYS);

    assert_hit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stb |=> stack_q.slot[0] == $past(acc_line));

    assert_mru_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stb && acc_line == stack_q.slot[0]) |=> $stable(stack_q));

    assert_miss_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_stb && !hit_stb) |=> stack_q.slot[0] == $past(victim_line));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stb && !miss_stb) |=> $stable(stack_q));
endmodule

bind lru_shift_stack lru_stack_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_stb     (hit_stb),
    .miss_stb    (miss_stb),
    .acc_line    (acc_line),
    .victim_line (victim_line),
    .stack_q     (stack_q)
);

// File: tb/test_lru_shift_stack.sv
module test_lru_shift_stack;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_line = '0;
    logic       hit_stb = 1'b0;
    logic       miss_stb = 1'b0;
    logic [1:0] victim_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int model [4];

    lru_shift_stack i_lru_shift_stack (
        .clk(clk), .rst_n(rst_n), .acc_line(acc_line),
        .hit_stb(hit_stb), .miss_stb(miss_stb), .victim_line(victim_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int find_pos(int line);
        for (int i = 0; i < 4; i++) if (model[i] == line) return i;
        return 3;
    endfunction

    task automatic model_update(bit h, bit m, int a);
        int in_l;
        int p;
        if (!h && !m) return;
        in_l = h ? a : model[3];
        p = find_pos(in_l);
        for (int i = p; i > 0; i--) model[i] = model[i-1];
        model[0] = in_l;
    endtask

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: victim actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, update at posedge, sample at next negedge
    task automatic step(bit h, bit m, int a);
        hit_stb  = h;
        miss_stb = m;
        acc_line = 2'(a);
        model_update(h, m, a);
        @(negedge clk);
        hit_stb  = 1'b0;
        miss_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = i;
        @(negedge clk);
    endtask

    initial begin
        int tags [4];
        int refs [12];
        int hitl;
        int blk;
        void'($urandom(32'd1234));
        do_reset();
        check("R1 reset victim", victim_line, 3);

        // R4: hit to bottom line, victim becomes former third line (2)
        step(1, 0, 3);
        check("R4 hit on bottom", victim_line, 2);
        // R3: hit to top (3 now on top) changes nothing
        step(1, 0, 3);
        check("R3 hit on top", victim_line, 2);
        // R7: idle cycles keep order
        step(0, 0, 1);
        step(0, 0, 2);
        check("R7 idle stable", victim_line, 2);
        // R2: hit to middle line 0 -> order 0,3,1,2
        step(1, 0, 0);
        check("R2 hit middle", victim_line, model[3]);
        // R5: miss with acc_line pointing elsewhere; victim 2 goes top -> 2,0,3,1
        step(0, 1, 0);
        check("R5 miss acc ignored", victim_line, 1);
        check("R5 model agrees", victim_line, model[3]);
        // R6: both strobes, hit to line 1 wins -> 1,2,0,3
        step(1, 1, 1);
        check("R6 hit priority", victim_line, 3);
        // R5/R9: consecutive misses rotate through the order
        step(0, 1, 3);
        check("R5 miss rotate 1", victim_line, 0);
        step(0, 1, 1);
        check("R5 miss rotate 2", victim_line, 2);

        // R8: reference string a b c d a b e a b c d e (blocks 0..4)
        do_reset();
        refs = '{0, 1, 2, 3, 0, 1, 4, 0, 1, 2, 3, 4};
        for (int i = 0; i < 4; i++) tags[i] = -1;
        foreach (refs[k]) begin
            blk  = refs[k];
            hitl = -1;
            for (int i = 0; i < 4; i++) if (tags[i] == blk) hitl = i;
            if (hitl >= 0) begin
                step(1, 0, hitl);
            end else begin
                tags[victim_line] = blk;
                step(0, 1, 0);
            end
        end
        check("R8 ref string victim holds b", victim_line, 2);
        check("R8 victim block is b", tags[victim_line], 1);

        // R2/R5/R6/R7/R9: random mix against the model
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            step(r < 6 || r == 9, r >= 6 && r != 8, int'($urandom_range(0, 3)));
            check("R2 random mix", victim_line, model[3]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule